// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves blocks of 32-bit words between host memory and a local endpoint RAM. The work is described by a chain of descriptors held in a table in host memory. Software programs a four-word header through a simple register write port. Word 0 carries the global option flags. Words 1 and 2 carry the 64-bit table address. A write to word 3 gives the index of the last ready descriptor and starts the engine. The engine fetches each 16-byte descriptor in turn and copies the stated number of words. A parameter fixes the copy direction. After each descriptor the engine can write the index it has just finished back into a workspace word of the table, and it can raise a one-cycle interrupt pulse.

Software learns that a chain is finished in one of two ways. It can preset the workspace word to an impossible value and poll until it reads the last-ready index. It can also wait for the interrupt. Writing the pattern 0x0000FFFF to header word 0 aborts the engine at any point and returns it to idle.

Top module: `cdma_engine`

## Requirements
- R1: While idle, a write to header word 3 (regAddr 3) loads the last-ready index from bits 7:0 and sets busy in the following cycle. The first host request then reads table base + 0x10, which is word 0 of descriptor 0.
- R2: The table base is {word 1, word 2}, with word 1 the high half. Every host request carries that high half in hostAddr[63:32] when the table and the data buffers share it.
- R3: Descriptors are processed in ascending index order from 0 up to the last-ready index. Descriptor i sits at base + 0x10 + 16*i. Its word 0 bits 15:0 give the length in 32-bit words. Word 1 is the endpoint byte address. Word 2 holds the high half of the host byte address and word 3 the low half. Exactly that many words are moved, and nothing beyond them is touched.
- R4: With DIR=0, word k of a descriptor is read from host address + 4*k and written to endpoint RAM word (endpoint address >> 2) + k.
- R5: With DIR=1, endpoint RAM word (endpoint address >> 2) + k is read and written to host address + 4*k.
- R6: A descriptor of length 0 completes without any endpoint RAM access and without any host data access.
- R7: When bit 18 of header word 0 is set, the engine writes each completed descriptor's index, zero-extended to 32 bits, to base + 0x0C. After a chain ends, that word equals the last-ready index.
- R8: When global writeback is clear, the write to base + 0x0C happens only for descriptors whose word 0 bit 18 is set. With no such descriptor, the preset workspace value is kept.
- R9: A descriptor's completion produces a single one-cycle interrupt pulse when bit 17 of header word 0 or bit 16 of that descriptor's word 0 is set. No pulse is produced otherwise.
- R10: A write of exactly 0x0000FFFF to header word 0 returns the engine to idle (busy low) in the next cycle, even when it lands in the same cycle as a host acknowledge. No further host request follows until a new start.
- R11: A host request holds its address and direction until it is acknowledged. Busy falls after the last-ready descriptor completes, and while idle no host or endpoint access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Header register write strobe |
| regAddr | input | 2 | Header word index 0..3 |
| regWrData | input | 32 | Header write data |
| hostReq | output | 1 | Host memory request, held until acknowledged |
| hostWe | output | 1 | 1 = host write, 0 = host read |
| hostAddr | output | 64 | Host byte address |
| hostWdata | output | 32 | Host write data |
| hostAck | input | 1 | One-cycle acknowledge; read data valid with it |
| hostRdata | input | 32 | Host read data |
| epEn | output | 1 | Endpoint RAM access enable |
| epWe | output | 1 | Endpoint RAM write enable |
| epAddr | output | EP_AW | Endpoint RAM word address |
| epWdata | output | 32 | Endpoint RAM write data |
| epRdata | input | 32 | Endpoint RAM read data, one cycle after a read |
| busy | output | 1 | Engine is working through a chain |
| irqPulse | output | 1 | One-cycle completion interrupt |

## Verification
The two events that can fall in the same clock edge are a soft-reset write and the acknowledge of a pending host request. The bench provokes this by asserting the 0x0000FFFF write to word 0 in the very window in which the host model has raised the acknowledge for the sixth transfer of a chain, in both copy directions. The outcome is judged at the ports. Busy must be low at the next sample. No host request may appear for the following 30 cycles. The workspace word must keep its preset value, and no interrupt may have fired. A fresh chain started afterwards must then complete normally.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  localparam logic [31:0] SOFT_RST_WORD = 32'h0000_FFFF;
  localparam int GLB_WB_BIT  = 18;
  localparam int GLB_IRQ_BIT = 17;
  localparam int DSC_IRQ_BIT = 16;
  localparam int DSC_WB_BIT  = 18;
  localparam int WS_LAST_OFS = 12;
  localparam int DESC_OFS    = 16;

  typedef enum logic [1:0] {
    ADDR_DESC = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_WB   = 2'd2
  } addrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     startLoad;
    logic     capDesc;
    logic     fetchInc;
    logic     fetchClr;
    logic     wordClr;
    logic     wordInc;
    logic     idxInc;
    logic     capHost;
    logic     capEp;
    addrSel_e addrSel;
  } strobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic [1:0] fetchK;
    logic       lenZero;
    logic       lastWord;
    logic       lastDesc;
    logic       wbWanted;
    logic       irqWanted;
  } status_t;

endpackage

// File: rtl/cdma_dpath.sv
module cdma_dpath
  import cdma_pkg::*;
#(
  parameter int EP_AW = 10,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  logic             hdrWrOk,
  input  strobe_t          strb,
  output status_t          stat,
  input  logic [31:0]      hostRdata,
  input  logic [31:0]      epRdata,
  output logic [63:0]      hostAddr,
  output logic [31:0]      hostWdata,
  output logic [EP_AW-1:0] epAddr,
  output logic [31:0]      epWdata
);

  localparam int LEN_W = 16;

  logic             glbWb, glbIrq;
  logic [31:0]      tblHi, tblLo;
  logic [IDX_W-1:0] lastIdx, curIdx;
  logic [1:0]       fetchK;
  logic [LEN_W-1:0] dLen, wordCnt;
  logic             dIrq, dWb;
  logic [EP_AW-1:0] dEp;
  logic [31:0]      dHi, dLo, dataQ;

  // header registers: accepted only while idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      glbWb   <= 1'b0;
      glbIrq  <= 1'b0;
      tblHi   <= '0;
      tblLo   <= '0;
      lastIdx <= '0;
    end else if (regWrEn && hdrWrOk) begin
      case (regAddr)
        2'd0: begin
          glbWb  <= regWrData[GLB_WB_BIT];
          glbIrq <= regWrData[GLB_IRQ_BIT];
        end
        2'd1: tblHi <= regWrData;
        2'd2: tblLo <= regWrData;
        default: lastIdx <= regWrData[IDX_W-1:0];
      endcase
    end
  end

  // descriptor walk state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx  <= '0;
      fetchK  <= '0;
      wordCnt <= '0;
    end else begin
      if (strb.startLoad)     curIdx <= '0;
      else if (strb.idxInc)   curIdx <= curIdx + 1'b1;

      if (strb.startLoad || strb.fetchClr) fetchK <= '0;
      else if (strb.fetchInc)              fetchK <= fetchK + 1'b1;

      if (strb.wordClr)       wordCnt <= '0;
      else if (strb.wordInc)  wordCnt <= wordCnt + 1'b1;
    end
  end

  // descriptor capture and data staging
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dLen  <= '0;
      dIrq  <= 1'b0;
      dWb   <= 1'b0;
      dEp   <= '0;
      dHi   <= '0;
      dLo   <= '0;
      dataQ <= '0;
    end else begin
      if (strb.capDesc) begin
        case (fetchK)
          2'd0: begin
            dLen <= hostRdata[LEN_W-1:0];
            dIrq <= hostRdata[DSC_IRQ_BIT];
            dWb  <= hostRdata[DSC_WB_BIT];
          end
          2'd1: dEp <= hostRdata[EP_AW+1:2];
          2'd2: dHi <= hostRdata;
          default: dLo <= hostRdata;
        endcase
      end
      if (strb.capHost)    dataQ <= hostRdata;
      else if (strb.capEp) dataQ <= epRdata;
    end
  end

  logic [63:0] tblBase, descAddr, dataAddr, wbAddr;

  always_comb begin
    tblBase  = {tblHi, tblLo};
    descAddr = tblBase + 64'(DESC_OFS)
             + {{(64-IDX_W-4){1'b0}}, curIdx, 4'b0000}
             + {60'd0, fetchK, 2'b00};
    dataAddr = {dHi, dLo} + {46'd0, wordCnt, 2'b00};
    wbAddr   = tblBase + 64'(WS_LAST_OFS);
    case (strb.addrSel)
      ADDR_DESC: hostAddr = descAddr;
      ADDR_WB:   hostAddr = wbAddr;
      default:   hostAddr = dataAddr;
    endcase
    hostWdata = (strb.addrSel == ADDR_WB) ? {{(32-IDX_W){1'b0}}, curIdx} : dataQ;
    epAddr    = dEp + wordCnt[EP_AW-1:0];
    epWdata   = dataQ;
  end

  always_comb begin
    stat.fetchK    = fetchK;
    stat.lenZero   = (dLen == '0);
    stat.lastWord  = (wordCnt == dLen - 1'b1);
    stat.lastDesc  = (curIdx == lastIdx);
    stat.wbWanted  = glbWb | dWb;
    stat.irqWanted = glbIrq | dIrq;
  end

endmodule

// File: rtl/cdma_ctrl.sv
module cdma_ctrl
  import cdma_pkg::*;
#(
  parameter int DIR = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  input  status_t     stat,
  input  logic        hostAck,
  output strobe_t     strb,
  output logic        hostReq,
  output logic        hostWe,
  output logic        epEn,
  output logic        epWe,
  output logic        busy,
  output logic        irqPulse
);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_HRD, S_EWR, S_ERD, S_EWAIT, S_HWR, S_WB, S_DONE
  } state_e;

  state_e state, nxt, finState, firstData;
  logic   softRst, startReq;

  assign softRst  = regWrEn && (regAddr == 2'd0) && (regWrData == SOFT_RST_WORD);
  assign startReq = regWrEn && (regAddr == 2'd3) && (state == S_IDLE);

  // direction variant chosen at elaboration
  generate
    if (DIR == 0) begin : g_h2e
      assign firstData = S_HRD;
    end else begin : g_e2h
      assign firstData = S_ERD;
    end
  endgenerate

  assign finState = stat.wbWanted ? S_WB : S_DONE;

  always_ff @(posedge clk) begin
    if (!rstN || softRst) state <= S_IDLE;
    else                  state <= nxt;
  end

  always_comb begin
    nxt     = state;
    strb    = '0;
    strb.addrSel = ADDR_DATA;
    hostReq = 1'b0;
    hostWe  = 1'b0;
    epEn    = 1'b0;
    epWe    = 1'b0;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          strb.startLoad = 1'b1;
          nxt = S_FETCH;
        end
      end
      S_FETCH: begin
        hostReq = 1'b1;
        strb.addrSel = ADDR_DESC;
        if (hostAck) begin
          strb.capDesc = 1'b1;
          if (stat.fetchK == 2'd3) nxt = S_CHECK;
          else                     strb.fetchInc = 1'b1;
        end
      end
      S_CHECK: begin
        strb.wordClr = 1'b1;
        nxt = stat.lenZero ? finState : firstData;
      end
      S_HRD: begin
        hostReq = 1'b1;
        if (hostAck) begin
          strb.capHost = 1'b1;
          nxt = S_EWR;
        end
      end
      S_EWR: begin
        epEn = 1'b1;
        epWe = 1'b1;
        strb.wordInc = 1'b1;
        nxt = stat.lastWord ? finState : S_HRD;
      end
      S_ERD: begin
        epEn = 1'b1;
        nxt = S_EWAIT;
      end
      S_EWAIT: begin
        strb.capEp = 1'b1;
        nxt = S_HWR;
      end
      S_HWR: begin
        hostReq = 1'b1;
        hostWe  = 1'b1;
        if (hostAck) begin
          strb.wordInc = 1'b1;
          nxt = stat.lastWord ? finState : S_ERD;
        end
      end
      S_WB: begin
        hostReq = 1'b1;
        hostWe  = 1'b1;
        strb.addrSel = ADDR_WB;
        if (hostAck) nxt = S_DONE;
      end
      S_DONE: begin
        if (stat.lastDesc) nxt = S_IDLE;
        else begin
          strb.idxInc   = 1'b1;
          strb.fetchClr = 1'b1;
          nxt = S_FETCH;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign irqPulse = (state == S_DONE) && stat.irqWanted;

endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter int DIR   = 0,
  parameter int EP_AW = 10,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic             hostReq,
  output logic             hostWe,
  output logic [63:0]      hostAddr,
  output logic [31:0]      hostWdata,
  input  logic             hostAck,
  input  logic [31:0]      hostRdata,
  output logic             epEn,
  output logic             epWe,
  output logic [EP_AW-1:0] epAddr,
  output logic [31:0]      epWdata,
  input  logic [31:0]      epRdata,
  output logic             busy,
  output logic             irqPulse
);

  strobe_t strb;
  status_t stat;

  cdma_ctrl #(.DIR(DIR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .stat(stat), .hostAck(hostAck), .strb(strb),
    .hostReq(hostReq), .hostWe(hostWe),
    .epEn(epEn), .epWe(epWe),
    .busy(busy), .irqPulse(irqPulse)
  );

  cdma_dpath #(.EP_AW(EP_AW), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .hdrWrOk(!busy), .strb(strb), .stat(stat),
    .hostRdata(hostRdata), .epRdata(epRdata),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .epAddr(epAddr), .epWdata(epWdata)
  );

endmodule

// File: rtl/cdma_checker.sv
module cdma_checker #(
  parameter int DIR   = 0,
  parameter int EP_AW = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic             hostReq,
  input logic             hostWe,
  input logic [63:0]      hostAddr,
  input logic             hostAck,
  input logic             epEn,
  input logic             epWe,
  input logic [EP_AW-1:0] epAddr,
  input logic             busy,
  input logic             irqPulse
);

  logic softRst;
  assign softRst = regWrEn && (regAddr == 2'd0) && (regWrData == 32'h0000_FFFF);

  // R1: start write while idle makes the engine busy
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && regWrEn && regAddr == 2'd3) |=> busy);

  // R10: soft reset returns to idle next cycle
  a_r10_soft_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !busy);

  // R11: pending request held stable until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostAck && !softRst) |=> (hostReq && $stable(hostAddr) && $stable(hostWe)));

  // R11: idle engine makes no accesses
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!hostReq && !epEn));

  // R9: interrupt is a single-cycle pulse
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R4 / R5: endpoint access kind follows the direction
  a_r4_r5_ep_dir: assert property (@(posedge clk) disable iff (!rstN)
    epEn |-> (epWe == (DIR == 0)));

  // R6 boundary: endpoint address stays constant-free of X while enabled
  a_r6_ep_known: assert property (@(posedge clk) disable iff (!rstN)
    epEn |-> !$isunknown(epAddr));

endmodule

bind cdma_engine cdma_checker #(.DIR(DIR), .EP_AW(EP_AW)) u_chk (
  .clk(clk), .rstN(rstN),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr), .hostAck(hostAck),
  .epEn(epEn), .epWe(epWe), .epAddr(epAddr),
  .busy(busy), .irqPulse(irqPulse)
);

// File: tb/tb_cdma_engine.sv
module tb_cdma_engine;

  localparam int CLK_PERIOD = 10;
  localparam int EP_AW = 10;
  localparam logic [31:0] TBL_LO = 32'h0000_2000;
  localparam logic [31:0] TBL_HI = 32'h0000_0001;
  localparam int WS_WORD = 12'h803;
  localparam logic [31:0] SENT = 32'h5EA7_5EA7;
  localparam logic [31:0] FADE = 32'h0000_FADE;

  logic clk = 1'b0;
  logic rstN;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             regWrEn   [2];
  logic [1:0]       regAddr   [2];
  logic [31:0]      regWrData [2];
  logic             hostReq   [2];
  logic             hostWe    [2];
  logic [63:0]      hostAddr  [2];
  logic [31:0]      hostWdata [2];
  logic             hostAck   [2];
  logic [31:0]      hostRdata [2];
  logic             epEn      [2];
  logic             epWe      [2];
  logic [EP_AW-1:0] epAddr    [2];
  logic [31:0]      epWdata   [2];
  logic [31:0]      epRdata   [2];
  logic             busy      [2];
  logic             irqPulse  [2];

  logic [31:0] hostMem [2][4096];
  logic [31:0] epMem   [2][1024];
  int          irqCnt  [2];
  int          ackCnt  [2];
  logic        badHi   [2];
  logic        armFirst[2];
  logic [63:0] firstAddr[2];

  int nChecks = 0;
  int nFail   = 0;

  cdma_engine #(.DIR(0), .EP_AW(EP_AW)) dut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn[0]), .regAddr(regAddr[0]), .regWrData(regWrData[0]),
    .hostReq(hostReq[0]), .hostWe(hostWe[0]), .hostAddr(hostAddr[0]),
    .hostWdata(hostWdata[0]), .hostAck(hostAck[0]), .hostRdata(hostRdata[0]),
    .epEn(epEn[0]), .epWe(epWe[0]), .epAddr(epAddr[0]), .epWdata(epWdata[0]),
    .epRdata(epRdata[0]), .busy(busy[0]), .irqPulse(irqPulse[0])
  );

  cdma_engine #(.DIR(1), .EP_AW(EP_AW)) dut2 (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn[1]), .regAddr(regAddr[1]), .regWrData(regWrData[1]),
    .hostReq(hostReq[1]), .hostWe(hostWe[1]), .hostAddr(hostAddr[1]),
    .hostWdata(hostWdata[1]), .hostAck(hostAck[1]), .hostRdata(hostRdata[1]),
    .epEn(epEn[1]), .epWe(epWe[1]), .epAddr(epAddr[1]), .epWdata(epWdata[1]),
    .epRdata(epRdata[1]), .busy(busy[1]), .irqPulse(irqPulse[1])
  );

  // host memory and endpoint RAM models, one per engine
  for (genvar g = 0; g < 2; g++) begin : g_mdl
    int waitCnt = 0;
    always @(negedge clk) begin
      if (!rstN) begin
        hostAck[g] = 1'b0;
        waitCnt = 0;
      end else if (hostAck[g]) begin
        hostAck[g] = 1'b0;
      end else if (hostReq[g]) begin
        if (waitCnt >= (ackCnt[g] % 3)) begin
          if (hostAddr[g][63:32] != TBL_HI) badHi[g] = 1'b1;
          if (armFirst[g]) begin
            firstAddr[g] = hostAddr[g];
            armFirst[g] = 1'b0;
          end
          if (hostWe[g]) hostMem[g][hostAddr[g][13:2]] = hostWdata[g];
          else           hostRdata[g] = hostMem[g][hostAddr[g][13:2]];
          hostAck[g] = 1'b1;
          ackCnt[g]++;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
    always @(posedge clk) begin
      if (epEn[g]) begin
        if (epWe[g]) epMem[g][epAddr[g]] <= epWdata[g];
        else         epRdata[g] <= epMem[g][epAddr[g]];
      end
      if (rstN && irqPulse[g]) irqCnt[g] <= irqCnt[g] + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int e, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regWrEn[e] = 1'b1; regAddr[e] = a; regWrData[e] = d;
    @(negedge clk); #1;
    regWrEn[e] = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int e, input int run, input int i, input int k);
    return 32'hC0DE_0000 ^ (32'(run) << 20) ^ (32'(e) << 16) ^ (32'(i) << 8) ^ 32'(k * 3 + 1);
  endfunction

  int lenA[8];
  logic [15:0] dflA[8];
  int runNo = 0;

  // runs a chain of n descriptors on engine e and judges all outcomes
  task automatic runChain(input int e, input int n, input bit gWb, input bit gIrq);
    int irq0, expIrq, wait_c;
    logic [31:0] expWs;
    runNo++;
    for (int i = 0; i < n; i++) begin
      hostMem[e][12'h804 + 4*i]     = {dflA[i], 16'(lenA[i])};
      hostMem[e][12'h804 + 4*i + 1] = 32'(i * 256);
      hostMem[e][12'h804 + 4*i + 2] = TBL_HI;
      hostMem[e][12'h804 + 4*i + 3] = 32'(i * 1024);
      for (int k = 0; k < lenA[i]; k++) begin
        if (e == 0) begin
          hostMem[e][256*i + k] = pat(e, runNo, i, k);
          epMem[e][64*i + k] = 32'd0;
        end else begin
          epMem[e][64*i + k] = pat(e, runNo, i, k);
          hostMem[e][256*i + k] = 32'd0;
        end
      end
      if (e == 0) epMem[e][64*i + lenA[i]] = SENT;
      else        hostMem[e][256*i + lenA[i]] = SENT;
    end
    hostMem[e][WS_WORD] = FADE;
    irq0 = irqCnt[e];
    badHi[e] = 1'b0;
    armFirst[e] = 1'b1;
    regWrite(e, 2'd0, 32'(n) | (32'(gWb) << 18) | (32'(gIrq) << 17));
    regWrite(e, 2'd1, TBL_HI);
    regWrite(e, 2'd2, TBL_LO);
    regWrite(e, 2'd3, 32'(n - 1));
    check(busy[e] == 1'b1, "R1 busy after start", 64'(busy[e]), 64'd1);
    wait_c = 0;
    while (busy[e] && wait_c < 8000) begin
      @(negedge clk); #1;
      wait_c++;
    end
    check(busy[e] == 1'b0, "R11 busy falls at chain end", 64'(busy[e]), 64'd0);
    check(firstAddr[e] == {TBL_HI, TBL_LO + 32'h10}, "R1 first fetch address",
          firstAddr[e], {TBL_HI, TBL_LO + 32'h10});
    check(badHi[e] == 1'b0, "R2 host address high half", 64'(badHi[e]), 64'd0);
    expIrq = 0;
    expWs = FADE;
    for (int i = 0; i < n; i++) begin
      if (gIrq || dflA[i][0]) expIrq++;
      if (gWb || dflA[i][2]) expWs = 32'(i);
      for (int k = 0; k < lenA[i]; k++) begin
        if (e == 0)
          check(epMem[e][64*i + k] == pat(e, runNo, i, k), "R4 host-to-endpoint word",
                64'(epMem[e][64*i + k]), 64'(pat(e, runNo, i, k)));
        else
          check(hostMem[e][256*i + k] == pat(e, runNo, i, k), "R5 endpoint-to-host word",
                64'(hostMem[e][256*i + k]), 64'(pat(e, runNo, i, k)));
      end
      if (e == 0)
        check(epMem[e][64*i + lenA[i]] == SENT, lenA[i] == 0 ? "R6 zero length untouched" : "R3 length bound",
              64'(epMem[e][64*i + lenA[i]]), 64'(SENT));
      else
        check(hostMem[e][256*i + lenA[i]] == SENT, lenA[i] == 0 ? "R6 zero length untouched" : "R3 length bound",
              64'(hostMem[e][256*i + lenA[i]]), 64'(SENT));
    end
    check(hostMem[e][WS_WORD] == expWs, gWb ? "R7 global writeback index" : "R8 local writeback index",
          64'(hostMem[e][WS_WORD]), 64'(expWs));
    check(irqCnt[e] - irq0 == expIrq, "R9 interrupt count",
          64'(irqCnt[e] - irq0), 64'(expIrq));
  endtask

  // soft reset landing on the same edge as the sixth acknowledge
  task automatic softResetOnAck(input int e);
    int acks, irq0;
    for (int i = 0; i < 2; i++) begin
      hostMem[e][12'h804 + 4*i]     = 32'h0004_0008;
      hostMem[e][12'h804 + 4*i + 1] = 32'(i * 256);
      hostMem[e][12'h804 + 4*i + 2] = TBL_HI;
      hostMem[e][12'h804 + 4*i + 3] = 32'(i * 1024);
    end
    hostMem[e][WS_WORD] = FADE;
    irq0 = irqCnt[e];
    regWrite(e, 2'd0, 32'h0006_0002);
    regWrite(e, 2'd1, TBL_HI);
    regWrite(e, 2'd2, TBL_LO);
    regWrite(e, 2'd3, 32'd1);
    acks = 0;
    while (acks < 6) begin
      @(negedge clk); #1;
      if (hostAck[e]) acks++;
    end
    regWrEn[e] = 1'b1; regAddr[e] = 2'd0; regWrData[e] = 32'h0000_FFFF;
    @(negedge clk); #1;
    regWrEn[e] = 1'b0;
    check(busy[e] == 1'b0, "R10 idle after soft reset", 64'(busy[e]), 64'd0);
    begin
      bit sawReq = 1'b0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk); #1;
        if (hostReq[e]) sawReq = 1'b1;
      end
      check(!sawReq, "R10 no request after soft reset", 64'(sawReq), 64'd0);
    end
    check(hostMem[e][WS_WORD] == FADE, "R10 workspace untouched", 64'(hostMem[e][WS_WORD]), 64'(FADE));
    check(irqCnt[e] == irq0, "R10 no interrupt after abort", 64'(irqCnt[e] - irq0), 64'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 2; e++) begin
      regWrEn[e] = 1'b0; regAddr[e] = '0; regWrData[e] = '0;
      irqCnt[e] = 0; ackCnt[e] = 0; badHi[e] = 1'b0; armFirst[e] = 1'b0;
      firstAddr[e] = '0; hostRdata[e] = '0; hostAck[e] = 1'b0;
    end
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    for (int e = 0; e < 2; e++) begin
      check(busy[e] == 1'b0, "R11 reset idle", 64'(busy[e]), 64'd0);
      check(hostReq[e] == 1'b0 && epEn[e] == 1'b0, "R11 reset quiet", 64'(hostReq[e]), 64'd0);
      check(irqPulse[e] == 1'b0, "R9 reset no interrupt", 64'(irqPulse[e]), 64'd0);
    end
    rstN = 1'b1;
    @(negedge clk);

    for (int e = 0; e < 2; e++) begin
      // directed cases
      lenA[0] = 5; dflA[0] = 16'h0;
      runChain(e, 1, 1'b1, 1'b0);
      lenA[0] = 4; lenA[1] = 0; lenA[2] = 7;
      dflA[0] = 0; dflA[1] = 0; dflA[2] = 0;
      runChain(e, 3, 1'b1, 1'b1);
      lenA[0] = 1; lenA[1] = 3; lenA[2] = 0; lenA[3] = 2;
      dflA[0] = 0; dflA[1] = 16'h4; dflA[2] = 0; dflA[3] = 16'h1;
      runChain(e, 4, 1'b0, 1'b0);
      lenA[0] = 0; lenA[1] = 0; dflA[0] = 0; dflA[1] = 0;
      runChain(e, 2, 1'b0, 1'b0);
      // abort on an acknowledge edge, then restart
      softResetOnAck(e);
      lenA[0] = 16; lenA[1] = 9; dflA[0] = 16'h1; dflA[1] = 0;
      runChain(e, 2, 1'b1, 1'b1);
      // sweep chain lengths and flag combinations
      for (int n = 1; n <= 4; n++) begin
        for (int f = 0; f < 4; f++) begin
          for (int i = 0; i < n; i++) begin
            lenA[i] = (i * 5 + n + f) % 6;
            dflA[i] = 16'(((i + f) % 3 == 0) ? 16'h4 : 16'h0) | 16'(((i + n) % 2) ? 16'h1 : 16'h0);
          end
          runChain(e, n, f[0], f[1]);
        end
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule